// File: doc/BRIEF.md
# External Memory Cycle Stretch Sequencer

This block times the external data-memory bus cycles of a small 8-bit processor core. The core hands it a single-cycle request carrying an address, write data and a direction flag. The block then runs one complete bus access. First it pulses an address-latch strobe. Next it waits out a setup interval with the address driven. It then holds the active-low read or write strobe low, and finally it keeps the address and any write data stable through a hold interval. Read data is captured inside the block and presented on `rd_data`. A one-clock `done` pulse marks the end of the access, and `busy` covers the whole access.

A 3-bit stretch setting picks the access length. The extra time is not spread evenly across the phases. Setting 0 is the fastest access, at 8 clocks. Setting 1 gives one clock to setup, one clock to hold and the rest to the strobe. Settings 2 and 3 grow only the strobe. Settings 4 to 7 add a whole 4-clock step to each of the latch pulse, the setup and the hold, and lengthen the strobe as well. The stretch setting is sampled when a request is accepted, so software may rewrite it at any time.

Top module: `xmem_stretch_seq`

## Requirements
- R1: After synchronous reset, and while idle, `busy`, `done`, `ale`, `addr_oe` and `dout_oe` are 0 and both `rd_n` and `wr_n` are 1.
- R2: An accepted access runs its phases in this order: `ale` high, then setup (address only), then strobe, then hold. `addr_oe` is high and `mem_addr` is stable for every busy cycle. Only `rd_n` (when `req_we`=0) or only `wr_n` (when `req_we`=1) goes low, never both, and never while `ale` is high.
- R3: The strobe stays low for 2, 4, 8, 12, 16, 20, 24 and 28 clocks for stretch values 0 to 7.
- R4: `ale` is high for 2 clocks for stretch 0 to 3, and for 6 clocks for stretch 4 to 7.
- R5: The setup interval (after `ale` falls and before the strobe) is 2 clocks for stretch 0, 3 clocks for stretch 1 to 3 and 7 clocks for stretch 4 to 7. The hold interval (after the strobe rises and while still busy) has the same lengths.
- R6: `busy` stays high for 8, 12, 16, 20, 36, 40, 44 and 48 clocks for stretch values 0 to 7, starting the clock after the request is accepted.
- R7: `done` is high for exactly one clock per access, and that clock is the last busy clock.
- R8: For a read, `rd_data` takes the value on `mem_din` during the last clock that `rd_n` is low. It keeps that value until the next read captures a new one.
- R9: For a write, `dout_oe` is high through setup, strobe and hold (setup+strobe+hold clocks), and `mem_dout` equals the request's write data whenever `dout_oe` is high. `dout_oe` is never high during a read.
- R10: The stretch value is sampled in the accepting cycle. A change to `stretch` during an access does not alter that access's timing.
- R11: A request arriving while `busy` is high is ignored. It neither alters the running access nor starts a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Single-cycle access request, accepted only when idle |
| req_we | input | 1 | Direction: 1 write, 0 read |
| req_addr | input | AW (16) | Access address |
| req_wdata | input | DW (8) | Write data |
| stretch | input | 3 | Stretch setting, 0 to 7 |
| busy | output | 1 | High for every clock of an access |
| done | output | 1 | One-clock pulse on the last access clock |
| rd_data | output | DW (8) | Last captured read data |
| mem_addr | output | AW (16) | External address |
| addr_oe | output | 1 | External address drive enable |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| mem_dout | output | DW (8) | External write data |
| dout_oe | output | 1 | Write data drive enable |
| mem_din | input | DW (8) | External read data |

## Verification
The assertions assume a clean synchronous reset and inputs that change only between clock edges. They also assume `mem_din` may change on any cycle without affecting the strobe timing. They do not assume that `req` stays low while an access runs. The stimulus drives every input on the falling clock edge. It fires requests both at idle and, on purpose, in the middle of an access. It rewrites `stretch` during an access and varies `mem_din` on every strobe clock, so a capture on the wrong clock yields a different value.

// File: rtl/xmem_stretch_pkg.sv
package xmem_stretch_pkg;

    localparam int SW   = 3;   // stretch field width
    localparam int STEP = 4;   // clocks per stretch step
    localparam int BASE = 2;   // clocks per phase at full speed
    localparam int CW   = 5;   // phase counter width, holds up to 31

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [CW-1:0] ale_len;
        logic [CW-1:0] setup_len;
        logic [CW-1:0] strobe_len;
        logic [CW-1:0] hold_len;
    } timing_t;

    // Phase lengths in clocks for one stretch setting.
    function automatic timing_t timing_for(input logic [SW-1:0] s);
        timing_t t;
        logic    slow;
        slow = s[SW-1];
        t.ale_len   = slow ? CW'(BASE + STEP) : CW'(BASE);
        if (s == '0)
            t.setup_len = CW'(BASE);
        else if (slow)
            t.setup_len = CW'(BASE + 1 + STEP);
        else
            t.setup_len = CW'(BASE + 1);
        t.hold_len = t.setup_len;
        if (s == '0)
            t.strobe_len = CW'(BASE);
        else if (s == SW'(1))
            t.strobe_len = CW'(2 * BASE);
        else
            t.strobe_len = CW'(STEP * int'(s));
        return t;
    endfunction

endpackage

// File: rtl/xmem_timing_table.sv
module xmem_timing_table
    import xmem_stretch_pkg::*;
(
    input  logic [SW-1:0] stretch,
    output timing_t       timing
);
    always_comb timing = timing_for(stretch);
endmodule

// File: rtl/xmem_phase_fsm.sv
module xmem_phase_fsm
    import xmem_stretch_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  timing_t live_timing,
    output phase_e  phase,
    output logic    strobe_last,
    output logic    hold_last
);
    phase_e        ph_q;
    logic [CW-1:0] cnt_q;
    timing_t       tim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            tim_q <= '0;
        end else if (ph_q == PH_IDLE) begin
            if (start) begin
                ph_q  <= PH_ALE;
                cnt_q <= live_timing.ale_len - 1'b1;
                tim_q <= live_timing;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            unique case (ph_q)
                PH_ALE: begin
                    ph_q  <= PH_SETUP;
                    cnt_q <= tim_q.setup_len - 1'b1;
                end
                PH_SETUP: begin
                    ph_q  <= PH_STROBE;
                    cnt_q <= tim_q.strobe_len - 1'b1;
                end
                PH_STROBE: begin
                    ph_q  <= PH_HOLD;
                    cnt_q <= tim_q.hold_len - 1'b1;
                end
                default: begin
                    ph_q  <= PH_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign phase       = ph_q;
    assign strobe_last = (ph_q == PH_STROBE) && (cnt_q == '0);
    assign hold_last   = (ph_q == PH_HOLD) && (cnt_q == '0);
endmodule

// File: rtl/xmem_bus_drive.sv
module xmem_bus_drive
    import xmem_stretch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    input  phase_e        phase,
    input  logic          strobe_last,
    input  logic [DW-1:0] mem_din,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          addr_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] mem_dout,
    output logic          dout_oe
);
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          strobing;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            we_q    <= start_we;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (strobe_last && !we_q)
            rdata_q <= mem_din;
    end

    assign strobing = (phase == PH_STROBE);
    assign ale      = (phase == PH_ALE);
    assign addr_oe  = (phase != PH_IDLE);
    assign rd_n     = !(strobing && !we_q);
    assign wr_n     = !(strobing && we_q);
    assign dout_oe  = we_q && (phase == PH_SETUP || phase == PH_STROBE || phase == PH_HOLD);
    assign mem_addr = addr_q;
    assign mem_dout = wdata_q;
    assign rd_data  = rdata_q;
endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
    import xmem_stretch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [SW-1:0] stretch,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          addr_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] mem_dout,
    output logic          dout_oe,
    input  logic [DW-1:0] mem_din
);
    timing_t live_timing;
    phase_e  phase;
    logic    strobe_last;
    logic    hold_last;
    logic    accept;

    assign accept = req && (phase == PH_IDLE);

    xmem_timing_table u_table (
        .stretch (stretch),
        .timing  (live_timing)
    );

    xmem_phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .live_timing (live_timing),
        .phase       (phase),
        .strobe_last (strobe_last),
        .hold_last   (hold_last)
    );

    xmem_bus_drive #(.AW(AW), .DW(DW)) u_drive (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_we    (req_we),
        .start_addr  (req_addr),
        .start_wdata (req_wdata),
        .phase       (phase),
        .strobe_last (strobe_last),
        .mem_din     (mem_din),
        .rd_data     (rd_data),
        .mem_addr    (mem_addr),
        .addr_oe     (addr_oe),
        .ale         (ale),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .mem_dout    (mem_dout),
        .dout_oe     (dout_oe)
    );

    assign busy = (phase != PH_IDLE);
    assign done = hold_last;
endmodule

// File: rtl/xmem_stretch_checker.sv
module xmem_stretch_checker #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] mem_addr,
    input logic          addr_oe,
    input logic          ale,
    input logic          rd_n,
    input logic          wr_n,
    input logic [DW-1:0] mem_dout,
    input logic          dout_oe
);
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    p_ale_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));

    p_addr_driven_r2: assert property (@(posedge clk) disable iff (rst)
        (ale || !rd_n || !wr_n) |-> addr_oe);

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_addr));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_last_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> busy ##1 !busy);

    p_wr_oe_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> dout_oe);

    p_rd_no_oe_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !dout_oe);

    p_wr_data_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && $past(dout_oe)) |-> $stable(mem_dout));
endmodule

bind xmem_stretch_seq xmem_stretch_checker #(.AW(AW), .DW(DW)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_addr (mem_addr),
    .addr_oe  (addr_oe),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .mem_dout (mem_dout),
    .dout_oe  (dout_oe)
);

// File: tb/test_xmem_stretch_seq.sv
`timescale 1ns/1ps
module test_xmem_stretch_seq;
    localparam int AW = 16;
    localparam int DW = 8;

    // Expected values per stretch setting, written from the requirements.
    localparam int EXP_ALE[8]    = '{2, 2, 2, 2, 6, 6, 6, 6};
    localparam int EXP_SETUP[8]  = '{2, 3, 3, 3, 7, 7, 7, 7};
    localparam int EXP_STROBE[8] = '{2, 4, 8, 12, 16, 20, 24, 28};
    localparam int EXP_TOTAL[8]  = '{8, 12, 16, 20, 36, 40, 44, 48};

    logic          clk = 1'b0;
    logic          rst;
    logic          req;
    logic          req_we;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [2:0]    stretch;
    logic          busy, done, addr_oe, ale, rd_n, wr_n, dout_oe;
    logic [DW-1:0] rd_data, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xmem_stretch_seq #(.AW(AW), .DW(DW)) i_xmem_stretch_seq (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .stretch(stretch), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .addr_oe(addr_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .mem_dout(mem_dout), .dout_oe(dout_oe),
        .mem_din(mem_din)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one access and measures every phase at the falling edges.
    // new_s: stretch value written during the access (R10); poke: extra req mid-access (R11).
    task automatic run_access(input int s, input bit we, input logic [AW-1:0] addr,
                              input logic [DW-1:0] wdata, input logic [DW-1:0] base,
                              input int new_s, input bit poke);
        int  n_ale = 0, n_su = 0, n_st = 0, n_ho = 0, n_tot = 0, n_oe = 0;
        int  n_done = 0, done_at = -1, order_err = 0, wrong_strobe = 0;
        int  addr_err = 0, wdata_err = 0;
        int  ds = s;
        stretch   = 3'(s);
        req_we    = we;
        req_addr  = addr;
        req_wdata = wdata;
        req       = 1'b1;
        mem_din   = base;
        @(negedge clk);
        req       = 1'b0;
        stretch   = 3'(new_s);
        while (busy && n_tot < 100) begin
            n_tot++;
            if (poke && n_tot == 3) begin
                req = 1'b1; req_we = !we; req_addr = ~addr; stretch = 3'(new_s);
            end else begin
                req = 1'b0;
            end
            if (!addr_oe || mem_addr !== addr) addr_err++;
            if (dout_oe) begin
                n_oe++;
                if (mem_dout !== wdata) wdata_err++;
            end
            if (done) begin n_done++; done_at = n_tot; end
            if (ale) begin
                n_ale++;
                if (n_su != 0 || n_st != 0) order_err++;
            end else if (!rd_n || !wr_n) begin
                n_st++;
                if (n_ho != 0) order_err++;
                if ((we && rd_n == 1'b0) || (!we && wr_n == 1'b0)) wrong_strobe++;
                mem_din = base ^ DW'(n_st);
            end else if (n_st == 0) begin
                n_su++;
            end else begin
                n_ho++;
            end
            @(negedge clk);
        end
        req = 1'b0;
        check(n_ale == EXP_ALE[ds], $sformatf("R4 ale width s=%0d we=%0d", ds, we), n_ale, EXP_ALE[ds]);
        check(n_su == EXP_SETUP[ds], $sformatf("R5 setup s=%0d we=%0d", ds, we), n_su, EXP_SETUP[ds]);
        check(n_st == EXP_STROBE[ds], $sformatf("R3 strobe s=%0d we=%0d", ds, we), n_st, EXP_STROBE[ds]);
        check(n_ho == EXP_SETUP[ds], $sformatf("R5 hold s=%0d we=%0d", ds, we), n_ho, EXP_SETUP[ds]);
        check(n_tot == EXP_TOTAL[ds], $sformatf("R6 total s=%0d we=%0d", ds, we), n_tot, EXP_TOTAL[ds]);
        check(order_err == 0 && wrong_strobe == 0 && addr_err == 0,
              $sformatf("R2 order/strobe/addr s=%0d we=%0d", ds, we),
              order_err + wrong_strobe + addr_err, 0);
        check(n_done == 1 && done_at == n_tot, $sformatf("R7 done s=%0d we=%0d", ds, we), done_at, n_tot);
        if (we) begin
            check(n_oe == EXP_SETUP[ds] * 2 + EXP_STROBE[ds] && wdata_err == 0,
                  $sformatf("R9 write drive s=%0d", ds), n_oe, EXP_SETUP[ds] * 2 + EXP_STROBE[ds]);
        end else begin
            check(n_oe == 0, $sformatf("R9 no drive on read s=%0d", ds), n_oe, 0);
            check(rd_data == (base ^ DW'(EXP_STROBE[ds])), $sformatf("R8 read capture s=%0d", ds),
                  int'(rd_data), int'(base ^ DW'(EXP_STROBE[ds])));
        end
    endtask

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        rst = 1'b1; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
        stretch = '0; mem_din = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(!busy && !done && !ale && !addr_oe && !dout_oe && rd_n && wr_n,
              "R1 reset state", {busy, done, ale, addr_oe, dout_oe, rd_n, wr_n}, 7'b0000011);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && rd_n && wr_n && !ale, "R1 idle after reset", busy, 0);

        // Table walk: every stretch value, read then write.
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 2; w++) begin
                run_access(s, bit'(w), 16'h1200 + 16'(s * 16 + w), 8'hA0 + 8'(s),
                           8'h30 + 8'(s * 8), s, 1'b0);
                @(negedge clk);
            end
        end

        // R10: stretch rewritten during the access, fast to slow and slow to fast.
        run_access(0, 1'b0, 16'hBEEF, 8'h00, 8'h5A, 7, 1'b0);
        @(negedge clk);
        run_access(6, 1'b1, 16'h0F0F, 8'hC3, 8'h11, 0, 1'b0);
        @(negedge clk);

        // R11: request during busy ignored, no follow-on access.
        run_access(2, 1'b0, 16'h4321, 8'h00, 8'h77, 2, 1'b1);
        repeat (3) begin
            check(!busy && rd_n && wr_n, "R11 no queued access", busy, 0);
            @(negedge clk);
        end

        // R8: a write leaves the last read data untouched.
        held = rd_data;
        run_access(1, 1'b1, 16'h0042, 8'h9C, 8'hEE, 1, 1'b0);
        check(rd_data == held, "R8 rd_data held across write", int'(rd_data), int'(held));

        // R1: reset in the middle of an access returns to idle.
        stretch = 3'd5; req_we = 1'b0; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !addr_oe && rd_n && wr_n && !ale, "R1 reset mid-access", busy, 0);
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule